// File: doc/BRIEF.md
# Brownout Status Capture With Freeze

This block sits beside a supply-dip gain limiter and keeps three diagnostic fields for software: the limiter's current 4-bit engine state, the deepest protection level engaged so far, and the smallest 10-bit supply measurement seen. Level codes run from 0 to 6. Code 0 is the deepest level. A numerically smaller code is therefore a deeper engagement. Code 7 means no level has been engaged.

Software raises the freeze input before it reads. The fields then hold still, so the three values form one consistent snapshot. Lowering freeze clears all three fields, and tracking starts again. Each reading therefore covers only the interval since the previous read. The minimum-supply field is meaningful only while freeze is high.

The level indication and the supply sample are plain strobed inputs. A strobe is a one-cycle valid with no ready. The block never applies back-pressure: a strobe is taken in every cycle it is asserted. It is either folded into the minimum or discarded under the rules below. Freeze and the state word are plain control and status pins.

Top module: `bsc_status_capture`

## Requirements
- R1: While freeze is low and the cycle is not a clear cycle, the state field shows the state input one clock later.
- R2: While freeze is high, none of the three fields changes, whatever the other inputs do.
- R3: A clear cycle is a cycle in which freeze is low and freeze was high in the previous cycle. One clock after a clear cycle, the state field is 0, the lowest-level field is 7 and the minimum-supply field is 10'h3FF. Every input in the clear cycle is ignored.
- R4: After reset, the state field is 0, the lowest-level field is 7 and the minimum-supply field is 10'h3FF.
- R5: A level strobe whose 3-bit code is numerically smaller than the stored code replaces the stored code one clock later. A level strobe with an equal or larger code leaves the stored code unchanged.
- R6: A supply-sample strobe whose value is strictly lower than the stored minimum replaces the minimum one clock later. A sample strobe with an equal or higher value leaves the minimum unchanged.
- R7: If freeze rises in the same cycle as a level strobe or a sample strobe, freeze takes priority and the strobe is dropped.
- R8: A level code or a supply value presented without its strobe has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| freeze_i | input | 1 | High holds the snapshot; a high-to-low change clears the fields |
| state_i | input | 4 | Live engine state word |
| eng_valid_i | input | 1 | Level-engaged strobe |
| eng_level_i | input | 3 | Engaged level code, 0 deepest |
| smp_valid_i | input | 1 | Supply-sample strobe |
| smp_volt_i | input | 10 | Supply measurement |
| stat_state_o | output | 4 | Tracked engine state |
| stat_lowlvl_o | output | 3 | Deepest level engaged, 7 if none |
| stat_minv_o | output | 10 | Lowest supply seen |

## Verification
On every cycle, the assertions check the following:
- the fields stay still under freeze;
- the fields take their cleared values after a falling freeze edge;
- the two minimum fields never rise outside a clear;
- the state field follows its input;
- a lower strobed value is captured.

Other behaviour can only be shown by the bench scenarios, because it depends on a chosen ordering of inputs:
- the full ordering sweep of every pair of level codes;
- a long pseudo-random supply sequence;
- dropping a strobe that coincides with the freeze rise;
- ignoring every input in the clear cycle.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  // Per-cycle action applied to every status field.
  typedef enum logic [1:0] {
    BSC_TRACK = 2'd0,
    BSC_HOLD  = 2'd1,
    BSC_CLEAR = 2'd2
  } bsc_act_e;
endpackage

// File: rtl/bsc_freeze_ctl.sv
module bsc_freeze_ctl
  import bsc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     freeze_i,
  output logic     frz_q,
  output bsc_act_e act_o
);
  // Previous-cycle copy of freeze, used to find the falling edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frz_q <= 1'b0;
    else        frz_q <= freeze_i;
  end

  // A falling edge clears the fields. Freeze high holds them, including
  // the cycle in which freeze first rises.
  always_comb begin
    if (frz_q && !freeze_i) act_o = BSC_CLEAR;
    else if (freeze_i)      act_o = BSC_HOLD;
    else                    act_o = BSC_TRACK;
  end
endmodule

// File: rtl/bsc_state_reg.sv
module bsc_state_reg
  import bsc_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  bsc_act_e     act_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else begin
      unique case (act_i)
        BSC_CLEAR: q_o <= '0;
        BSC_TRACK: q_o <= d_i;
        default:   q_o <= q_o;
      endcase
    end
  end
endmodule

// File: rtl/bsc_min_track.sv
module bsc_min_track
  import bsc_pkg::*;
#(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  bsc_act_e     act_i,
  input  logic         vld_i,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] min_o
);
  localparam logic [W-1:0] EMPTY = {W{1'b1}};

  logic take;
  assign take = (act_i == BSC_TRACK) && vld_i && (val_i < min_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  min_o <= EMPTY;
    else if (act_i == BSC_CLEAR) min_o <= EMPTY;
    else if (take)               min_o <= val_i;
  end
endmodule

// File: rtl/bsc_status_capture.sv
module bsc_status_capture
  import bsc_pkg::*;
#(
  parameter int unsigned STATE_W = 4,
  parameter int unsigned LVL_W   = 3,
  parameter int unsigned VOLT_W  = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               freeze_i,
  input  logic [STATE_W-1:0] state_i,
  input  logic               eng_valid_i,
  input  logic [LVL_W-1:0]   eng_level_i,
  input  logic               smp_valid_i,
  input  logic [VOLT_W-1:0]  smp_volt_i,
  output logic [STATE_W-1:0] stat_state_o,
  output logic [LVL_W-1:0]   stat_lowlvl_o,
  output logic [VOLT_W-1:0]  stat_minv_o
);
  bsc_act_e act;
  logic     frz_q;

  bsc_freeze_ctl u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .freeze_i (freeze_i),
    .frz_q    (frz_q),
    .act_o    (act)
  );

  bsc_state_reg #(.W(STATE_W)) u_state (
    .clk   (clk),
    .rst_n (rst_n),
    .act_i (act),
    .d_i   (state_i),
    .q_o   (stat_state_o)
  );

  // The deepest level has the smallest code, so it is tracked as a minimum.
  bsc_min_track #(.W(LVL_W)) u_lvl (
    .clk   (clk),
    .rst_n (rst_n),
    .act_i (act),
    .vld_i (eng_valid_i),
    .val_i (eng_level_i),
    .min_o (stat_lowlvl_o)
  );

  bsc_min_track #(.W(VOLT_W)) u_volt (
    .clk   (clk),
    .rst_n (rst_n),
    .act_i (act),
    .vld_i (smp_valid_i),
    .val_i (smp_volt_i),
    .min_o (stat_minv_o)
  );
endmodule

// File: rtl/bsc_status_capture_chk.sv
module bsc_status_capture_chk #(
  parameter int unsigned STATE_W = 4,
  parameter int unsigned LVL_W   = 3,
  parameter int unsigned VOLT_W  = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               freeze_i,
  input logic               frz_q,
  input logic [STATE_W-1:0] state_i,
  input logic               smp_valid_i,
  input logic [VOLT_W-1:0]  smp_volt_i,
  input logic [STATE_W-1:0] stat_state_o,
  input logic [LVL_W-1:0]   stat_lowlvl_o,
  input logic [VOLT_W-1:0]  stat_minv_o
);
  logic fall_c;
  assign fall_c = frz_q && !freeze_i;

  p_track_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze_i && !fall_c) |=> stat_state_o == $past(state_i));

  p_frozen_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_i |=> ($stable(stat_state_o) && $stable(stat_lowlvl_o) && $stable(stat_minv_o)));

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fall_c |=> (stat_state_o == '0 && stat_lowlvl_o == {LVL_W{1'b1}}
                && stat_minv_o == {VOLT_W{1'b1}}));

  // R5: outside a clear, the lowest-level field never moves to a higher code.
  p_lvl_monotone_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_c |=> stat_lowlvl_o <= $past(stat_lowlvl_o));

  p_min_monotone_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_c |=> stat_minv_o <= $past(stat_minv_o));

  p_min_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid_i && !freeze_i && !fall_c && smp_volt_i < stat_minv_o)
      |=> stat_minv_o == $past(smp_volt_i));
endmodule

bind bsc_status_capture bsc_status_capture_chk #(
  .STATE_W(STATE_W), .LVL_W(LVL_W), .VOLT_W(VOLT_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .freeze_i      (freeze_i),
  .frz_q         (frz_q),
  .state_i       (state_i),
  .smp_valid_i   (smp_valid_i),
  .smp_volt_i    (smp_volt_i),
  .stat_state_o  (stat_state_o),
  .stat_lowlvl_o (stat_lowlvl_o),
  .stat_minv_o   (stat_minv_o)
);

// File: tb/tb_bsc_status_capture.sv
`timescale 1ns/1ps
module tb_bsc_status_capture;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n;
  logic       freeze_i;
  logic [3:0] state_i;
  logic       eng_valid_i;
  logic [2:0] eng_level_i;
  logic       smp_valid_i;
  logic [9:0] smp_volt_i;
  logic [3:0] stat_state_o;
  logic [2:0] stat_lowlvl_o;
  logic [9:0] stat_minv_o;

  bsc_status_capture dut (
    .clk(clk), .rst_n(rst_n), .freeze_i(freeze_i), .state_i(state_i),
    .eng_valid_i(eng_valid_i), .eng_level_i(eng_level_i),
    .smp_valid_i(smp_valid_i), .smp_volt_i(smp_volt_i),
    .stat_state_o(stat_state_o), .stat_lowlvl_o(stat_lowlvl_o),
    .stat_minv_o(stat_minv_o)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  // Expected values, worked out from the requirements.
  logic       m_fq;
  logic [3:0] m_s;
  logic [2:0] m_l;
  logic [9:0] m_v;

  task automatic chk(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_all(string tag);
    chk(tag, stat_state_o, m_s);
    chk(tag, stat_lowlvl_o, m_l);
    chk(tag, stat_minv_o, m_v);
  endtask

  task automatic step(string tag, logic frz, logic [3:0] st, logic ev,
                      logic [2:0] el, logic sv, logic [9:0] svl);
    @(negedge clk);
    freeze_i = frz; state_i = st; eng_valid_i = ev; eng_level_i = el;
    smp_valid_i = sv; smp_volt_i = svl;
    @(posedge clk);
    if (m_fq && !frz) begin
      m_s = 4'd0; m_l = 3'd7; m_v = 10'h3FF;
    end else if (!frz) begin
      m_s = st;
      if (ev && el < m_l) m_l = el;
      if (sv && svl < m_v) m_v = svl;
    end
    m_fq = frz;
    #1;
    chk_all(tag);
  endtask

  task automatic clear_all();
    step("R3", 1'b1, 4'd0, 1'b0, 3'd0, 1'b0, 10'd0);
    step("R3", 1'b0, 4'd0, 1'b0, 3'd0, 1'b0, 10'd0);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; freeze_i = 1'b0; state_i = '0; eng_valid_i = 1'b0;
    eng_level_i = '0; smp_valid_i = 1'b0; smp_volt_i = '0;
    m_fq = 1'b0; m_s = 4'd0; m_l = 3'd7; m_v = 10'h3FF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk_all("R4");

    // R1: every state code is tracked.
    for (int i = 0; i < 16; i++)
      step("R1", 1'b0, 4'(i), 1'b0, 3'd0, 1'b0, 10'd0);

    // R5: every ordered pair of level codes, starting from an empty field.
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++) begin
        clear_all();
        step("R5", 1'b0, 4'(a), 1'b1, 3'(a), 1'b0, 10'd0);
        step("R5", 1'b0, 4'(b), 1'b1, 3'(b), 1'b0, 10'd0);
      end

    // R6: a pseudo-random supply sequence, then an equal value.
    clear_all();
    for (int i = 0; i < 96; i++)
      step("R6", 1'b0, 4'(i), 1'b0, 3'd0, 1'b1, 10'((i * 389 + 101) % 1024));
    step("R6", 1'b0, 4'd3, 1'b0, 3'd0, 1'b1, m_v);

    // R8: values presented without their strobes.
    clear_all();
    step("R8", 1'b0, 4'd2, 1'b1, 3'd5, 1'b1, 10'd700);
    step("R8", 1'b0, 4'd4, 1'b0, 3'd0, 1'b0, 10'd0);
    step("R8", 1'b0, 4'd6, 1'b0, 3'd1, 1'b0, 10'd1);

    // R7: freeze rises together with deep strobes, which are dropped.
    step("R7", 1'b1, 4'd9, 1'b1, 3'd0, 1'b1, 10'd0);
    // R2: frozen fields stay put under busy inputs.
    for (int i = 0; i < 40; i++)
      step("R2", 1'b1, 4'(i), 1'b1, 3'(i), 1'b1, 10'(i * 7));

    // R3: the clear cycle ignores its inputs; tracking resumes afterwards.
    step("R3", 1'b0, 4'd9, 1'b1, 3'd0, 1'b1, 10'd0);
    step("R1", 1'b0, 4'd11, 1'b1, 3'd4, 1'b1, 10'd300);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule